// File: doc/BRIEF.md
# Memory Controller Event Counter Unit

This block counts activity inside a DRAM controller. Eight programmable slots each hold a 64-bit setup word. Bit 63 of that word arms the slot, and the lower 63 bits pick which event lines the slot watches. The event sources are outside the block. They arrive each cycle as a 63-bit pulse vector. Two further counters are fixed in function: one counts DRAM reads and the other counts DRAM writes. These two have their own arm bits and their own clear strobes.

A single global run flag gates every counter. Software raises the flag with a start write and drops it with an end write. All access goes through a plain 64-bit register port. Writes are strobed by `reg_we`. Read data is combinational from `reg_addr`. The port has no handshake: every access completes in one cycle and cannot be back-pressured.

Each counter is `CNT_W` bits wide (48 by default) and has a sticky wrap flag. A value read returns the count in the low bits and the wrap flag at bit `CNT_W`.

Top module: `mc_evt_counter_unit`

## Requirements
- R1: After reset, every counter value, every wrap flag, the run flag, the ended flag, the fixed-counter arm bits and the mode bit read as zero.
- R2: Writing data with bit 0 set to 0x8028 starts counting, and 0x8028 then reads 2, meaning bit 1 shows the run flag. Writing data with bit 0 set to 0x8030 stops counting and sets bit 0 of 0x8038. The next start write clears that bit again.
- R3: The setup word of slot n is readable and writable at 0x8040+8n. While the slot is armed (bit 63 set) and counting runs, its count rises by exactly 1 in every cycle where the event vector ANDed with bits 62:0 of the setup word is nonzero. This holds even when several selected lines are high in the same cycle, as with a 4-bit field such as bits 29:26.
- R4: A slot does not change in a cycle where it is disarmed, or where none of its selected lines is high.
- R5: Any write to a slot's setup word zeroes that slot's count and wrap flag in the same edge. This takes priority over an increment in that cycle.
- R6: The value of slot n is read at 0x8080+8n. Writes to these addresses have no effect.
- R7: The fixed-counter arm register at 0x80C0 is readable and writable. Its bit 0 arms the write counter, fed by `dram_wr_evt`, and its bit 1 arms the read counter, fed by `dram_rd_evt`. Each armed counter adds 1 per cycle in which its input is high while counting runs.
- R8: A write to 0x80C8 zeroes the write counter if data bit 0 is set, and the read counter if data bit 1 is set. The clear wins over an increment in the same cycle. The register reads back 0.
- R9: The fixed write counter reads at 0x80D0 and the fixed read counter reads at 0x80D8. Both use the same layout as the slot values.
- R10: An increment from the all-ones count gives a count of 0 and sets the wrap flag. The flag stays set until a clear write or a setup-word write to that counter.
- R11: Reads of any address not listed in R2 to R12 return 0. This includes addresses that are not 8-byte aligned.
- R12: Bit 0 of the mode register at 0x8020 (1 selects manual operation) is readable and writable.
- R13: While the run flag is low, no counter changes, even if it is armed and its events are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr, combinational |
| evt_vec | input | 63 | Per-cycle event pulses for the programmable slots |
| dram_rd_evt | input | 1 | DRAM read pulse for the fixed read counter |
| dram_wr_evt | input | 1 | DRAM write pulse for the fixed write counter |

## Verification
The hardest case to reach from the ports is the wrap of a counter. At the default width it needs 2^48 events, and no register lets software preload a count. The bench therefore builds the unit with an 8-bit count width. That keeps the register layout and moves the wrap flag to bit 8. The bench then holds an event line high for 256 cycles, checks that the count returns to 0 with the flag set, and checks that the flag stays set across one more increment. Clear-versus-increment collisions are produced by raising a pulse in the same cycle as the clear write.

// File: rtl/mcpm_pkg.sv
package mcpm_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 64;
  localparam int SEL_W   = DATA_W - 1;
  localparam int ARM_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] A_MODE    = 16'h8020;
  localparam logic [ADDR_W-1:0] A_START   = 16'h8028;
  localparam logic [ADDR_W-1:0] A_END     = 16'h8030;
  localparam logic [ADDR_W-1:0] A_ENDSTAT = 16'h8038;
  localparam logic [ADDR_W-1:0] A_CFG0    = 16'h8040;
  localparam logic [ADDR_W-1:0] A_VAL0    = 16'h8080;
  localparam logic [ADDR_W-1:0] A_FX_ARM  = 16'h80C0;
  localparam logic [ADDR_W-1:0] A_FX_CLR  = 16'h80C8;
  localparam logic [ADDR_W-1:0] A_FX_WVAL = 16'h80D0;
  localparam logic [ADDR_W-1:0] A_FX_RVAL = 16'h80D8;

  typedef enum logic [0:0] {FX_WR = 1'b0, FX_RD = 1'b1} fx_sel_e;
endpackage

// File: rtl/mcpm_counter.sv
module mcpm_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      val  <= '0;
      wrap <= 1'b0;
    end else if (inc) begin
      if (val == {W{1'b1}}) begin
        val  <= '0;
        wrap <= 1'b1;
      end else begin
        val <= val + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcpm_ctrl.sv
module mcpm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_mode,
  input  logic wr_start,
  input  logic wr_end,
  input  logic wbit0,
  output logic mode_q,
  output logic run_q,
  output logic ended_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      run_q   <= 1'b0;
      ended_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wbit0;
      if (wr_start && wbit0) begin
        run_q   <= 1'b1;
        ended_q <= 1'b0;
      end else if (wr_end && wbit0) begin
        run_q   <= 1'b0;
        ended_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcpm_prog_slot.sv
module mcpm_prog_slot
  import mcpm_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wd,
  input  logic              run,
  input  logic [SEL_W-1:0]  evt,
  output logic [DATA_W-1:0] cfg_q,
  output logic [CNT_W-1:0]  val,
  output logic              wrap
);
  logic hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wd;
  end

  assign hit = cfg_q[ARM_BIT] && run && ((evt & cfg_q[SEL_W-1:0]) != '0);

  mcpm_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cfg_we),
    .inc  (hit),
    .val  (val),
    .wrap (wrap)
  );
endmodule

// File: rtl/mc_evt_counter_unit.sv
module mc_evt_counter_unit
  import mcpm_pkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int CNT_W    = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [SEL_W-1:0]  evt_vec,
  input  logic              dram_rd_evt,
  input  logic              dram_wr_evt
);
  localparam int NUM_FX = 2;
  localparam int PAD_W  = DATA_W - CNT_W - 1;

  logic mode_q, run_q, ended_q;
  logic [DATA_W-1:0] cfg_q    [NUM_PROG];
  logic [CNT_W-1:0]  prog_val [NUM_PROG];
  logic              prog_ovf [NUM_PROG];
  logic [CNT_W-1:0]  fx_val   [NUM_FX];
  logic              fx_ovf   [NUM_FX];
  logic [NUM_FX-1:0] fx_arm_q;
  logic [NUM_FX-1:0] fx_clr;
  logic [NUM_FX-1:0] fx_inc;

  function automatic logic [DATA_W-1:0] pack_val(input logic [CNT_W-1:0] v, input logic o);
    return {{PAD_W{1'b0}}, o, v};
  endfunction

  mcpm_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mode (reg_we && reg_addr == A_MODE),
    .wr_start(reg_we && reg_addr == A_START),
    .wr_end  (reg_we && reg_addr == A_END),
    .wbit0   (reg_wdata[0]),
    .mode_q  (mode_q),
    .run_q   (run_q),
    .ended_q (ended_q)
  );

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_slot
    mcpm_prog_slot #(.CNT_W(CNT_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg_we(reg_we && reg_addr == A_CFG0 + ADDR_W'(8 * i)),
      .cfg_wd(reg_wdata),
      .run   (run_q),
      .evt   (evt_vec),
      .cfg_q (cfg_q[i]),
      .val   (prog_val[i]),
      .wrap  (prog_ovf[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             fx_arm_q <= '0;
    else if (reg_we && reg_addr == A_FX_ARM) fx_arm_q <= reg_wdata[NUM_FX-1:0];
  end

  assign fx_clr = (reg_we && reg_addr == A_FX_CLR) ? reg_wdata[NUM_FX-1:0] : '0;
  assign fx_inc[FX_WR] = run_q && fx_arm_q[FX_WR] && dram_wr_evt;
  assign fx_inc[FX_RD] = run_q && fx_arm_q[FX_RD] && dram_rd_evt;

  for (genvar j = 0; j < NUM_FX; j++) begin : g_fx
    mcpm_counter #(.W(CNT_W)) u_fx (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (fx_clr[j]),
      .inc  (fx_inc[j]),
      .val  (fx_val[j]),
      .wrap (fx_ovf[j])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE:    reg_rdata[0] = mode_q;
      A_START:   reg_rdata[1] = run_q;
      A_ENDSTAT: reg_rdata[0] = ended_q;
      A_FX_ARM:  reg_rdata[NUM_FX-1:0] = fx_arm_q;
      A_FX_WVAL: reg_rdata = pack_val(fx_val[FX_WR], fx_ovf[FX_WR]);
      A_FX_RVAL: reg_rdata = pack_val(fx_val[FX_RD], fx_ovf[FX_RD]);
      default: begin
        for (int i = 0; i < NUM_PROG; i++) begin
          if (reg_addr == A_CFG0 + ADDR_W'(8 * i)) reg_rdata = cfg_q[i];
          if (reg_addr == A_VAL0 + ADDR_W'(8 * i)) reg_rdata = pack_val(prog_val[i], prog_ovf[i]);
        end
      end
    endcase
  end
endmodule

// File: rtl/mcpm_checker.sv
module mcpm_checker
  import mcpm_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              run_q,
  input logic [CNT_W-1:0]  val0,
  input logic              ovf0
);
  AST_RUN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_START && reg_wdata[0]) |=> run_q); // R2
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_END && reg_wdata[0]) |=> !run_q); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (val0 == $past(val0) || val0 == $past(val0) + 1 || val0 == '0)); // R3
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reg_we) |=> ($stable(val0) && $stable(ovf0))); // R13
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf0 && !reg_we) |=> ovf0); // R10
  AST_LOW_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < A_MODE) |-> (reg_rdata == '0)); // R11
endmodule

bind mc_evt_counter_unit mcpm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .run_q    (run_q),
  .val0     (prog_val[0]),
  .ovf0     (prog_ovf[0])
);

// File: tb/sim_mc_evt_counter_unit.sv
module sim_mc_evt_counter_unit;
  localparam int CW = 8;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;
  localparam logic [63:0] CFG0 = 64'h8000_0000_0000_0001;
  localparam logic [63:0] CFG1 = 64'h8000_0000_3C00_0000;
  localparam logic [63:0] CFG2 = 64'h0000_0000_0000_0004;
  localparam int NV = 52;
  // row: {op, requirement, addr, data (or event vector), expected (or {rd,wr} pulses)}
  localparam logic [149:0] VEC [NV] = '{
    {OP_RD, 4'd2,  16'h8028, 64'h0, 64'h0},        // R2 idle
    {OP_WR, 4'd3,  16'h8040, CFG0, 64'h0},         // R3
    {OP_WR, 4'd3,  16'h8048, CFG1, 64'h0},         // R3 4-lane field
    {OP_WR, 4'd4,  16'h8050, CFG2, 64'h0},         // R4 disarmed
    {OP_EV, 4'd13, 16'h0, 64'h1, 64'h0},           // R13
    {OP_RD, 4'd13, 16'h8080, 64'h0, 64'h0},
    {OP_WR, 4'd2,  16'h8028, 64'h1, 64'h0},
    {OP_RD, 4'd2,  16'h8028, 64'h0, 64'h2},
    {OP_EV, 4'd3,  16'h0, 64'h5, 64'h0},
    {OP_RD, 4'd3,  16'h8080, 64'h0, 64'h1},
    {OP_RD, 4'd4,  16'h8090, 64'h0, 64'h0},
    {OP_EV, 4'd3,  16'h0, 64'h3C00_0000, 64'h0},
    {OP_RD, 4'd3,  16'h8088, 64'h0, 64'h1},
    {OP_RD, 4'd3,  16'h8080, 64'h0, 64'h1},
    {OP_EV, 4'd3,  16'h0, 64'h1000_0001, 64'h0},
    {OP_RD, 4'd3,  16'h8080, 64'h0, 64'h2},
    {OP_RD, 4'd3,  16'h8088, 64'h0, 64'h2},
    {OP_EV, 4'd4,  16'h0, 64'h20, 64'h0},          // R4 no selected line
    {OP_RD, 4'd4,  16'h8080, 64'h0, 64'h2},
    {OP_RD, 4'd4,  16'h8088, 64'h0, 64'h2},
    {OP_WR, 4'd6,  16'h8080, 64'h55, 64'h0},       // R6 ignored write
    {OP_RD, 4'd6,  16'h8080, 64'h0, 64'h2},
    {OP_RD, 4'd3,  16'h8040, 64'h0, CFG0},
    {OP_WR, 4'd7,  16'h80C0, 64'h3, 64'h0},        // R7
    {OP_RD, 4'd7,  16'h80C0, 64'h0, 64'h3},
    {OP_EV, 4'd7,  16'h0, 64'h0, 64'h3},
    {OP_EV, 4'd7,  16'h0, 64'h0, 64'h2},
    {OP_RD, 4'd9,  16'h80D8, 64'h0, 64'h2},        // R9
    {OP_RD, 4'd9,  16'h80D0, 64'h0, 64'h1},
    {OP_WR, 4'd8,  16'h80C8, 64'h1, 64'h0},        // R8
    {OP_RD, 4'd8,  16'h80D0, 64'h0, 64'h0},
    {OP_RD, 4'd8,  16'h80D8, 64'h0, 64'h2},
    {OP_RD, 4'd8,  16'h80C8, 64'h0, 64'h0},
    {OP_WR, 4'd7,  16'h80C0, 64'h2, 64'h0},
    {OP_EV, 4'd7,  16'h0, 64'h0, 64'h3},
    {OP_RD, 4'd7,  16'h80D8, 64'h0, 64'h3},
    {OP_RD, 4'd7,  16'h80D0, 64'h0, 64'h0},
    {OP_WR, 4'd2,  16'h8030, 64'h1, 64'h0},
    {OP_RD, 4'd2,  16'h8038, 64'h0, 64'h1},
    {OP_RD, 4'd2,  16'h8028, 64'h0, 64'h0},
    {OP_EV, 4'd13, 16'h0, 64'h1, 64'h3},
    {OP_RD, 4'd13, 16'h8080, 64'h0, 64'h2},
    {OP_WR, 4'd12, 16'h8020, 64'h1, 64'h0},        // R12
    {OP_RD, 4'd12, 16'h8020, 64'h0, 64'h1},
    {OP_RD, 4'd11, 16'h8010, 64'h0, 64'h0},        // R11
    {OP_RD, 4'd11, 16'h8044, 64'h0, 64'h0},
    {OP_RD, 4'd11, 16'h80E0, 64'h0, 64'h0},
    {OP_RD, 4'd11, 16'h8100, 64'h0, 64'h0},
    {OP_WR, 4'd2,  16'h8028, 64'h1, 64'h0},
    {OP_RD, 4'd2,  16'h8038, 64'h0, 64'h0},
    {OP_WR, 4'd5,  16'h8040, CFG0, 64'h0},         // R5
    {OP_RD, 4'd5,  16'h8080, 64'h0, 64'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [62:0] evt_vec = '0;
  logic        dram_rd_evt = 1'b0;
  logic        dram_wr_evt = 1'b0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mc_evt_counter_unit #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_vec(evt_vec),
    .dram_rd_evt(dram_rd_evt), .dram_wr_evt(dram_wr_evt)
  );

  task automatic wr_reg(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic chk_rd(input logic [15:0] a, input logic [63:0] exp, input int req);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL R%0d addr=%h actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic fire(input logic [62:0] e, input logic rd, input logic wr);
    @(negedge clk);
    evt_vec = e; dram_rd_evt = rd; dram_wr_evt = wr;
    @(negedge clk);
    evt_vec = '0; dram_rd_evt = 1'b0; dram_wr_evt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd(16'h8080, 64'h0, 1);
    chk_rd(16'h80D0, 64'h0, 1);
    chk_rd(16'h80D8, 64'h0, 1);
    chk_rd(16'h8028, 64'h0, 1);
    chk_rd(16'h8038, 64'h0, 1);
    chk_rd(16'h80C0, 64'h0, 1);
    chk_rd(16'h8020, 64'h0, 1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][149:148])
        OP_WR: wr_reg(VEC[i][143:128], VEC[i][127:64]);
        OP_RD: chk_rd(VEC[i][143:128], VEC[i][63:0], int'(VEC[i][147:144]));
        default: fire(VEC[i][126:64], VEC[i][1], VEC[i][0]);
      endcase
    end

    // R10 wrap of slot 3 and slot 0 with an 8-bit count
    wr_reg(16'h8058, CFG0);
    @(negedge clk);
    evt_vec = 63'h1;
    repeat (256) @(negedge clk);
    evt_vec = '0;
    chk_rd(16'h8098, 64'h100, 10);
    chk_rd(16'h8080, 64'h100, 10);
    fire(63'h1, 1'b0, 1'b0);
    chk_rd(16'h8098, 64'h101, 10);
    wr_reg(16'h8058, CFG0);
    chk_rd(16'h8098, 64'h0, 5);
    chk_rd(16'h8080, 64'h101, 10);

    // R8 clear wins over a simultaneous increment on the read counter
    @(negedge clk);
    dram_rd_evt = 1'b1; reg_we = 1'b1; reg_addr = 16'h80C8; reg_wdata = 64'h2;
    @(negedge clk);
    dram_rd_evt = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    chk_rd(16'h80D8, 64'h0, 8);
    // R5 setup write wins over a simultaneous hit
    @(negedge clk);
    evt_vec = 63'h1; reg_we = 1'b1; reg_addr = 16'h8040; reg_wdata = CFG0;
    @(negedge clk);
    evt_vec = '0; reg_we = 1'b0; reg_wdata = '0;
    chk_rd(16'h8080, 64'h0, 5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule